// File: doc/BRIEF.md
# Periodic Compare Timer

This block is a memory-mapped timer peripheral built around a 32-bit down-counter. Software programs a load value, a compare value and a control word through a small word-addressed register bus. The counter steps on a prescaled tick taken from one of three tick-enable inputs. When it reaches zero it either reloads from the load register or wraps to all-ones and keeps running.

Whenever a step lands the counter on the compare value, a sticky status flag is raised. The flag, gated by the compare-interrupt enable and the timer enable, drives a level interrupt. The control word also provides:
- a software reset that keeps only a few mode bits;
- an optional restart of the counter when the timer is enabled;
- an overwrite option that copies each new load value straight into the counter.

Top module: `pit_timer`

## Requirements
- R1: Word offsets decode as 0 control, 1 status, 2 load, 3 compare, 4 current count. Any other offset reads zero. Read data is combinational and shows the state before a write made in the same cycle.
- R2: A control write stores bits 25:0, and bits 31:26 read zero. The software-reset bit (bit 16) always reads back 0. Hardware reset gives control 0, status 0, load 0xFFFFFFFF, compare 0 and count 0.
- R3: The clock-source field (bits 25:24) picks the tick source. Code 00 halts counting. Codes 01, 10 and 11 select tick_en_i[0], tick_en_i[1] and tick_en_i[2].
- R4: The prescale field (bits 15:4) holds a value P. While the timer is enabled (bit 0), the counter steps once per P+1 selected ticks. The divide count is cleared while the timer is disabled and on a software reset. A step occurs on a selected tick whose divide count is at least P.
- R5: A step from a non-zero count decrements it. A step from zero loads the load register when reload mode (bit 3) is set, and loads 0xFFFFFFFF otherwise.
- R6: A control write that raises enable from 0 to 1 with enable-mode (bit 1) set restarts the counter. It restarts from the load value if bit 3 is set in the written word, and from 0xFFFFFFFF otherwise. With bit 1 clear, the held count is kept.
- R7: A load write with the overwrite bit (bit 17) set also copies the value into the counter on that edge, and this replaces any step in that cycle. With bit 17 clear the counter is untouched.
- R8: The status flag (status bit 0) is set when a step moves the counter onto the compare value while compare-interrupt enable (bit 2) is set. A step replaced by a forced counter load sets nothing. A set in the same cycle as a clear wins.
- R9: A status write with bit 0 set clears the flag. A status write with bit 0 clear has no effect.
- R10: irq_o is high exactly when the flag, bit 2 and bit 0 are all set.
- R11: A control write with bit 16 set is a soft reset. The written bits 0, 1 and 18 to 21 are kept and every other control bit clears. Status becomes 0, load 0xFFFFFFFF, compare 0 and count 0.
- R12: While enable is clear the counter holds its value, whatever the ticks do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| tick_en_i | input | 3 | Tick-enable inputs, selected by the source field |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Word offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| irq_o | output | 1 | Level interrupt |

## Verification
A wrong divide count or a wrong wrap value shows up in the count register on the first step that uses it. That is one cycle after the offending tick, and every later value read from offset 4 is shifted as well. A mistaken flag update appears on irq_o and on status bit 0 in the cycle after the step that should or should not have matched. A control bit lost in a soft reset or during masking reads back wrong at once and changes every later step. Comparing all five registers against a cycle model on every cycle therefore catches an internal fault within a cycle or two of its cause.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int DATA_W = 32;
    localparam int PRE_W  = 12;
    localparam int CTRL_W = 26;
    localparam int SRC_W  = 2;

    localparam int B_EN    = 0;
    localparam int B_ENMOD = 1;
    localparam int B_CIE   = 2;
    localparam int B_RLD   = 3;
    localparam int B_PRE   = 4;
    localparam int B_SWR   = 16;
    localparam int B_OVW   = 17;
    localparam int B_SRC   = 24;

    localparam logic [CTRL_W-1:0] KEEP_MASK = CTRL_W'(26'h03C_0003);

    typedef enum logic [2:0] {
        OFF_CTRL = 3'd0,
        OFF_STAT = 3'd1,
        OFF_LOAD = 3'd2,
        OFF_CMP  = 3'd3,
        OFF_CNT  = 3'd4
    } reg_off_e;

    typedef struct packed {
        logic [CTRL_W-1:0] cr;
        logic              flag;
        logic [DATA_W-1:0] ld;
        logic [DATA_W-1:0] cmp;
    } regs_t;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
    parameter int N_SRC = 3,
    parameter int SRC_W = 2,
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             clr_i,
    input  logic [SRC_W-1:0] src_i,
    input  logic [PRE_W-1:0] div_i,
    input  logic [N_SRC-1:0] tick_i,
    output logic             step_o
);
    localparam int N_CODE = 1 << SRC_W;

    typedef struct packed {
        logic [PRE_W-1:0] div_cnt;
    } pre_t;

    pre_t        s_d, s_q;
    logic [N_CODE-1:0] src_vec;
    logic        sel_tick;

    assign src_vec[0] = 1'b0;
    for (genvar g = 1; g < N_CODE; g++) begin : g_src
        if (g <= N_SRC) begin : g_on
            assign src_vec[g] = tick_i[g-1];
        end else begin : g_off
            assign src_vec[g] = 1'b0;
        end
    end

    assign sel_tick = src_vec[src_i];

    always_comb begin
        s_d    = s_q;
        step_o = 1'b0;
        if (!en_i || clr_i) begin
            s_d.div_cnt = '0;
        end else if (sel_tick) begin
            if (s_q.div_cnt >= div_i) begin
                step_o      = 1'b1;
                s_d.div_cnt = '0;
            end else begin
                s_d.div_cnt = s_q.div_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4: with a non-zero divisor two steps never come back to back
    p_prescale_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> (!step_o || div_i == '0));
endmodule

// File: rtl/pit_counter.sv
module pit_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              rld_mode_i,
    input  logic [DATA_W-1:0] load_val_i,
    input  logic              force_i,
    input  logic [DATA_W-1:0] force_val_i,
    output logic [DATA_W-1:0] nxt_o,
    output logic [DATA_W-1:0] cnt_o
);
    typedef struct packed {
        logic [DATA_W-1:0] cnt;
    } cnt_t;

    cnt_t s_d, s_q;

    always_comb begin
        if (s_q.cnt == '0) nxt_o = rld_mode_i ? load_val_i : '1;
        else               nxt_o = s_q.cnt - 1'b1;
        s_d = s_q;
        if (force_i)     s_d.cnt = force_val_i;
        else if (step_i) s_d.cnt = nxt_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;

    // R12: no step and no forced load keeps the count
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !force_i) |=> $stable(cnt_o));
    // R5: free-running wrap from zero
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !force_i && cnt_o == '0 && !rld_mode_i) |=> cnt_o == '1);
    // R5: plain decrement
    p_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !force_i && cnt_o != '0) |=> cnt_o == $past(cnt_o) - 1'b1);
    // R7: a forced value lands on the next edge
    p_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
        force_i |=> cnt_o == $past(force_val_i));
endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int N_SRC  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  tick_en_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    regs_t             s_d, s_q;
    logic              step;
    logic              force_ld;
    logic [DATA_W-1:0] force_val;
    logic              soft_rst;
    logic              hit;
    logic [DATA_W-1:0] cnt_nxt;
    logic [DATA_W-1:0] cnt;
    logic              wr_ctrl, wr_stat, wr_load, wr_cmp;
    logic [CTRL_W-1:0] new_cr;

    assign wr_ctrl = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_CTRL));
    assign wr_stat = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_STAT));
    assign wr_load = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_LOAD));
    assign wr_cmp  = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_CMP));
    assign new_cr  = bus_wdata_i[CTRL_W-1:0];

    pit_prescaler #(
        .N_SRC (N_SRC),
        .SRC_W (SRC_W),
        .PRE_W (PRE_W)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (s_q.cr[B_EN]),
        .clr_i  (soft_rst),
        .src_i  (s_q.cr[B_SRC +: SRC_W]),
        .div_i  (s_q.cr[B_PRE +: PRE_W]),
        .tick_i (tick_en_i),
        .step_o (step)
    );

    pit_counter #(
        .DATA_W (DATA_W)
    ) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (step),
        .rld_mode_i  (s_q.cr[B_RLD]),
        .load_val_i  (s_q.ld),
        .force_i     (force_ld),
        .force_val_i (force_val),
        .nxt_o       (cnt_nxt),
        .cnt_o       (cnt)
    );

    always_comb begin
        s_d       = s_q;
        force_ld  = 1'b0;
        force_val = '0;
        soft_rst  = 1'b0;
        if (wr_ctrl) begin
            if (new_cr[B_SWR]) begin
                soft_rst  = 1'b1;
                s_d.cr    = new_cr & KEEP_MASK;
                s_d.flag  = 1'b0;
                s_d.ld    = ALL_ONES;
                s_d.cmp   = '0;
                force_ld  = 1'b1;
                force_val = '0;
            end else begin
                s_d.cr = new_cr;
                if (new_cr[B_EN] && !s_q.cr[B_EN] && new_cr[B_ENMOD]) begin
                    force_ld  = 1'b1;
                    force_val = new_cr[B_RLD] ? s_q.ld : ALL_ONES;
                end
            end
        end
        if (wr_stat && bus_wdata_i[0]) s_d.flag = 1'b0;
        if (wr_load) begin
            s_d.ld = bus_wdata_i;
            if (s_q.cr[B_OVW]) begin
                force_ld  = 1'b1;
                force_val = bus_wdata_i;
            end
        end
        if (wr_cmp) s_d.cmp = bus_wdata_i;
        hit = step && s_q.cr[B_CIE] && !force_ld && (cnt_nxt == s_q.cmp);
        if (hit) s_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cr   <= '0;
            s_q.flag <= 1'b0;
            s_q.ld   <= '1;
            s_q.cmp  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (bus_addr_i)
            ADDR_W'(OFF_CTRL): bus_rdata_o = DATA_W'(s_q.cr);
            ADDR_W'(OFF_STAT): bus_rdata_o = DATA_W'(s_q.flag);
            ADDR_W'(OFF_LOAD): bus_rdata_o = s_q.ld;
            ADDR_W'(OFF_CMP):  bus_rdata_o = s_q.cmp;
            ADDR_W'(OFF_CNT):  bus_rdata_o = cnt;
            default:           bus_rdata_o = '0;
        endcase
    end

    assign irq_o = s_q.flag && s_q.cr[B_CIE] && s_q.cr[B_EN];

    // R2: control only changes through a control write
    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ctrl |=> $stable(s_q.cr));
    // R2: the self-clearing reset bit never sticks
    p_swr_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> !s_q.cr[B_SWR]);
    // R9: a clearing status write without a new match drops the flag
    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && bus_wdata_i[0] && !step) |=> !s_q.flag);
    // R8: the flag is sticky without a clearing write
    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.flag && !(wr_stat && bus_wdata_i[0]) && !wr_ctrl) |=> s_q.flag);
    // R11: soft reset state
    p_soft_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && new_cr[B_SWR]) |=> (s_q.ld == ALL_ONES && cnt == '0 && !s_q.flag && s_q.cmp == '0));
endmodule

// File: tb/pit_timer_bench.sv
module pit_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  tick_en_i = '0;
    logic        bus_wr_i = 1'b0;
    logic [2:0]  bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    string tag = "R2";
    bit rnd_tags = 0;

    logic [25:0] m_cr;
    logic        m_sr;
    logic [31:0] m_ld, m_cmp, m_cnt;
    logic [11:0] m_pre;

    always #2 clk = ~clk;

    pit_timer u_pit_timer (
        .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en_i),
        .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
    );

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return {6'b0, m_cr};
            3'd1: return {31'b0, m_sr};
            3'd2: return m_ld;
            3'd3: return m_cmp;
            3'd4: return m_cnt;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string addr_tag(input logic [2:0] a);
        case (a)
            3'd0: return "R2";
            3'd1: return "R8";
            3'd2: return "R7";
            3'd4: return "R5";
            default: return "R1";
        endcase
    endfunction

    task automatic m_reset();
        m_cr = '0; m_sr = 0; m_ld = '1; m_cmp = '0; m_cnt = '0; m_pre = '0;
    endtask

    task automatic m_step(input logic wr, input logic [2:0] a, input logic [31:0] wd, input logic [2:0] tk);
        logic sel, step, setf;
        logic [31:0] cnt_n;
        logic [3:0] srcv;
        logic [25:0] nv;
        srcv = {tk, 1'b0};
        sel = srcv[m_cr[25:24]];
        step = 0;
        if (!m_cr[0]) m_pre = '0;
        else if (sel) begin
            if (m_pre >= m_cr[15:4]) begin step = 1; m_pre = '0; end
            else m_pre = m_pre + 1;
        end
        cnt_n = m_cnt;
        if (step) cnt_n = (m_cnt == 0) ? (m_cr[3] ? m_ld : 32'hFFFF_FFFF) : m_cnt - 1;
        setf = step && m_cr[2] && (cnt_n == m_cmp);
        if (wr) begin
            case (a)
                3'd0: begin
                    nv = wd[25:0];
                    if (nv[16]) begin
                        m_cr = nv & 26'h03C_0003; m_sr = 0; m_ld = '1; m_cmp = '0;
                        cnt_n = '0; setf = 0; m_pre = '0;
                    end else begin
                        if (nv[0] && !m_cr[0] && nv[1]) begin
                            cnt_n = nv[3] ? m_ld : 32'hFFFF_FFFF; setf = 0;
                        end
                        m_cr = nv;
                    end
                end
                3'd1: if (wd[0]) m_sr = 0;
                3'd2: begin
                    if (m_cr[17]) begin cnt_n = wd; setf = 0; end
                    m_ld = wd;
                end
                3'd3: m_cmp = wd;
                default: ;
            endcase
        end
        if (setf) m_sr = 1;
        m_cnt = cnt_n;
    endtask

    task automatic cyc(input logic wr, input logic [2:0] a, input logic [31:0] wd, input logic [2:0] tk);
        logic [31:0] exp_rd;
        logic exp_irq;
        string t;
        @(negedge clk);
        bus_wr_i = wr; bus_addr_i = a; bus_wdata_i = wd; tick_en_i = tk;
        #1;
        t = rnd_tags ? addr_tag(a) : tag;
        exp_rd = m_read(a);
        n_chk++;
        if (bus_rdata_o !== exp_rd) begin
            n_bad++;
            $display("FAIL %s rdata offset %0d: got %h expected %h", t, a, bus_rdata_o, exp_rd);
        end
        exp_irq = m_sr & m_cr[2] & m_cr[0];
        n_chk++;
        if (irq_o !== exp_irq) begin
            n_bad++;
            $display("FAIL R10 irq (%s phase): got %b expected %b", t, irq_o, exp_irq);
        end
        m_step(wr, a, wd, tk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] wd);
        cyc(1'b1, a, wd, 3'b000);
    endtask

    task automatic idle(input int n, input logic [2:0] tk);
        for (int i = 0; i < n; i++) cyc(1'b0, 3'(i % 8), 32'h0, tk);
    endtask

    initial begin
        #600000;
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        m_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 / R2: reset values at every offset, unused offsets zero
        tag = "R1"; idle(8, 3'b000);
        tag = "R2"; wr(0, 32'hFFFF_FFFF & ~32'h0001_0001); idle(8, 3'b000);
        // R3: source 00 halts even with ticks present
        tag = "R3"; wr(0, 32'h0002_0001); wr(2, 32'd50); idle(8, 3'b111);
        wr(0, 32'h0202_0001); idle(6, 3'b001); idle(6, 3'b010);
        wr(0, 32'h0302_0001); idle(6, 3'b011); idle(6, 3'b100);
        // R4: prescale of 3
        tag = "R4"; wr(0, 32'h0102_0031); idle(24, 3'b001);
        // R5: free-running wrap through zero
        tag = "R5"; wr(0, 32'h0102_0001); wr(2, 32'd2); idle(6, 3'b001);
        wr(0, 32'h0102_0009); wr(2, 32'd3); idle(10, 3'b001);
        // R7: load without overwrite leaves count alone
        tag = "R7"; wr(0, 32'h0100_0009); wr(2, 32'd1234); idle(4, 3'b000);
        // R12: disable holds count
        tag = "R12"; wr(0, 32'h0100_0008); idle(10, 3'b111);
        // R6: enable with enable-mode and reload, then without enable-mode
        tag = "R6"; wr(0, 32'h0100_000B); idle(4, 3'b001);
        wr(0, 32'h0100_0000); wr(0, 32'h0100_0003); idle(4, 3'b001);
        wr(0, 32'h0100_0000); wr(0, 32'h0100_0001); idle(4, 3'b001);
        // R8 / R10: match raises flag and irq
        tag = "R8"; wr(0, 32'h0102_0005); wr(2, 32'd10); wr(3, 32'd7); idle(8, 3'b001);
        tag = "R10"; wr(0, 32'h0102_0001); idle(3, 3'b000); wr(0, 32'h0102_0005); idle(3, 3'b000);
        // R9: write with bit 0 clear has no effect, then clear
        tag = "R9"; wr(1, 32'hFFFF_FFFE); idle(3, 3'b000); wr(1, 32'h1); idle(3, 3'b000);
        // R11: soft reset keeps only selected bits
        tag = "R11"; wr(0, 32'h03FF_FFFF); idle(8, 3'b111);
        // random phase
        void'($urandom(32'h5EED_0042));
        rnd_tags = 1;
        wr(0, 32'h0102_0005);
        for (int k = 0; k < 20000; k++) begin
            int r;
            logic [31:0] d;
            logic [2:0] a;
            r = $urandom % 100;
            d = $urandom;
            if (r < 6) begin
                a = 0;
                d[15:4] = 12'($urandom % 3);
                d[0] = ($urandom % 8) != 0;
                d[16] = ($urandom % 30) == 0;
            end else if (r < 14) a = 1;
            else if (r < 22) begin a = 2; if ($urandom % 4 != 0) d = $urandom % 24; end
            else if (r < 30) begin a = 3; if ($urandom % 4 != 0) d = m_cnt - ($urandom % 8); end
            else a = 3'($urandom % 8);
            cyc(r < 30, a, d, 3'($urandom));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule